// File: doc/BRIEF.md
# Automatic Buffered Serial Transfer Controller

This block runs a multi-byte exchange over a clocked synchronous serial link with no processor help. Software first fills a 16-entry byte buffer. It then loads a down-counting pointer with the byte count minus one and pulses a start strobe. The start strobe stands for a write to the serial data port. It carries no payload, and nothing from it ever reaches the serial line.

For each byte the sequencer does four things in order. It reads the buffer entry selected by the pointer and hands that byte to an 8-bit shift engine. The engine shifts the byte out MSB first while it shifts a byte in. The sequencer then writes the received byte back over the slot that held the transmit byte, and after that it decrements the pointer. So a block prepared at offsets n-1 down to 0 goes out in that order, and the replies land in the same slots. When the byte at offset 0 has been stored, a one-cycle completion interrupt is raised and the busy output drops.

Software reads the buffer through the same port it writes with. The read data appears one cycle after the address.

Top module: `auto_xfer_ctrl`

## Requirements
- R1: A pulse on `trig_we` while idle starts an exchange. The first byte on `sdo` is the buffer entry at the pointer value held at the start. The start strobe contributes no data bits.
- R2: The bytes are sent from buffer offsets P, P-1, ..., 0, where P is the pointer value at the start. Exactly P+1 bytes go out.
- R3: With receive enabled (`rx_en`=1 when the start strobe is seen), the k-th received byte is stored at the same offset as the k-th transmit byte. Buffer entries above P are left untouched.
- R4: With `rx_en`=0 when the start strobe is seen, no buffer entry changes. The exchange still sends P+1 bytes and still ends with the interrupt.
- R5: `sck` idles high. Each bit starts with a falling edge, at which `sdo` changes. `sdi` is sampled at the rising edge. `sdo` never changes while `sck` rises. Each byte has 8 rising edges, MSB first, and each `sck` phase lasts SCK_HALF clock cycles.
- R6: `irq` is a single-cycle pulse. It fires exactly once per exchange, after the last byte is stored, in the same cycle that `busy` is low again.
- R7: `busy` is high from the cycle after the accepted start strobe until completion. While `busy` is high, start strobes, software buffer writes and pointer writes are all ignored.
- R8: The pointer decrements by one only after a byte's store step. It reads 0 after completion, and the `ptr` output shows its current value.
- R9: After reset `busy`=0, `irq`=0, `sck`=1 and `ptr`=0.
- R10: A pointer value of 0 gives a one-byte exchange using offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_buf_we | input | 1 | Software buffer write strobe (ignored while busy) |
| sw_buf_addr | input | ADDR_W | Software buffer address for both read and write |
| sw_buf_wdata | input | DATA_W | Software buffer write data |
| sw_buf_rdata | output | DATA_W | Buffer read data, one cycle after the address |
| sw_ptr_we | input | 1 | Pointer load strobe (ignored while busy) |
| sw_ptr_wdata | input | ADDR_W | Pointer load value (byte count minus one) |
| rx_en | input | 1 | Receive enable, captured with the start strobe |
| trig_we | input | 1 | Start strobe, standing for a data-port write |
| ptr | output | ADDR_W | Current pointer value |
| busy | output | 1 | Exchange in progress |
| irq | output | 1 | Completion pulse |
| sck | output | 1 | Serial clock, idle high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench goes after several corner cases, each with a distinct symptom when wrong.

- Ordering and overwrite: a controller that fetched after storing without decrementing first, or that decremented before storing, would repeat or skip a byte or write the reply one slot off. The bench catches both by comparing every serial byte with a queue and by reading back all 16 entries.
- Disabled receive: a run with receive disabled must leave the buffer intact yet still finish.
- Strobes while busy: a start strobe, a buffer write and a pointer load of 0 are all issued mid-run. A design that honoured any of them would restart, corrupt offset 0 or end early.
- Size extremes: runs of one byte and the full 16 bytes exercise the pointer at zero and at its maximum.

// File: rtl/axc_pkg.sv
package axc_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_LOAD,
    SQ_SHIFT,
    SQ_STORE
  } seq_state_t;
endpackage

// File: rtl/axc_buffer.sv
module axc_buffer #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // registered read, single write port: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/axc_shifter.sv
module axc_shifter #(
  parameter int DATA_W   = 8,
  parameter int SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              sdi,
  output logic              sck,
  output logic              sdo,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(SCK_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

  logic              active;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic              rxbit;

  assign sdo = shreg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      sck     <= 1'b1;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      rxbit   <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        // first falling edge: MSB appears together with it
        active <= 1'b1;
        shreg  <= tx_byte;
        sck    <= 1'b0;
        cnt    <= '0;
        bitn   <= '0;
      end else if (active) begin
        if (cnt == CNT_LAST) begin
          cnt <= '0;
          if (!sck) begin
            sck   <= 1'b1;
            rxbit <= sdi;
          end else if (bitn == BIT_LAST) begin
            active  <= 1'b0;
            done    <= 1'b1;
            rx_byte <= {shreg[DATA_W-2:0], rxbit};
          end else begin
            sck   <= 1'b0;
            shreg <= {shreg[DATA_W-2:0], rxbit};
            bitn  <= bitn + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5: output bit holds across every rising serial-clock edge
  assert_sdo_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(sdo));

  // R5: serial clock idles high whenever the engine is not shifting
  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!active && !$past(start)) |-> sck);
endmodule

// File: rtl/axc_seq.sv
module axc_seq
  import axc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic              ptr_we,
  input  logic [ADDR_W-1:0] ptr_wdata,
  input  logic              rx_en,
  input  logic              sh_done,
  output logic [ADDR_W-1:0] ptr,
  output logic              busy,
  output logic              irq,
  output logic              ram_we,
  output logic              sh_start
);
  seq_state_t st;
  logic       rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SQ_IDLE;
      ptr  <= '0;
      busy <= 1'b0;
      irq  <= 1'b0;
      rx_q <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (ptr_we) ptr <= ptr_wdata;
          if (trig) begin
            busy <= 1'b1;
            rx_q <= rx_en;
            st   <= SQ_FETCH;
          end
        end
        SQ_FETCH: st <= SQ_LOAD;
        SQ_LOAD:  st <= SQ_SHIFT;
        SQ_SHIFT: if (sh_done) st <= SQ_STORE;
        SQ_STORE: begin
          // the store uses the old pointer; the decrement lands after it
          if (ptr == '0) begin
            st   <= SQ_IDLE;
            busy <= 1'b0;
            irq  <= 1'b1;
          end else begin
            ptr <= ptr - 1'b1;
            st  <= SQ_FETCH;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    ram_we   = (st == SQ_STORE) && rx_q;
    sh_start = (st == SQ_LOAD);
  end

  // R8: while busy the pointer only ever steps down by one
  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && ptr != $past(ptr)) |-> ptr == ADDR_W'($past(ptr) - 1'b1));

  // R6: completion is a single-cycle pulse
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R6: interrupt coincides with the end of busy
  assert_irq_idle_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!busy && $past(busy)));
endmodule

// File: rtl/auto_xfer_ctrl.sv
module auto_xfer_ctrl #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_buf_we,
  input  logic [ADDR_W-1:0] sw_buf_addr,
  input  logic [DATA_W-1:0] sw_buf_wdata,
  output logic [DATA_W-1:0] sw_buf_rdata,
  input  logic              sw_ptr_we,
  input  logic [ADDR_W-1:0] sw_ptr_wdata,
  input  logic              rx_en,
  input  logic              trig_we,
  output logic [ADDR_W-1:0] ptr,
  output logic              busy,
  output logic              irq,
  output logic              sck,
  output logic              sdo,
  input  logic              sdi
);
  logic              ctl_we;
  logic              sh_start;
  logic              sh_done;
  logic [DATA_W-1:0] sh_rx;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [ADDR_W-1:0] ram_raddr;
  logic [DATA_W-1:0] ram_wdata;

  // the sequencer owns the buffer port while an exchange runs
  always_comb begin
    ram_we    = busy ? ctl_we : sw_buf_we;
    ram_waddr = busy ? ptr    : sw_buf_addr;
    ram_wdata = busy ? sh_rx  : sw_buf_wdata;
    ram_raddr = busy ? ptr    : sw_buf_addr;
  end

  axc_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (sw_buf_rdata)
  );

  axc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig_we),
    .ptr_we    (sw_ptr_we),
    .ptr_wdata (sw_ptr_wdata),
    .rx_en     (rx_en),
    .sh_done   (sh_done),
    .ptr       (ptr),
    .busy      (busy),
    .irq       (irq),
    .ram_we    (ctl_we),
    .sh_start  (sh_start)
  );

  axc_shifter #(.DATA_W(DATA_W), .SCK_HALF(SCK_HALF)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (sh_start),
    .tx_byte (sw_buf_rdata),
    .sdi     (sdi),
    .sck     (sck),
    .sdo     (sdo),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  // R7: the sequencer writes the buffer only during an exchange
  assert_store_busy_R7: assert property (@(posedge clk) disable iff (rst)
    ctl_we |-> busy);

  // R7: an exchange begins only in response to a start strobe
  assert_start_trig_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(trig_we));

  // R1: a byte is handed to the shift engine only while busy
  assert_shift_busy_R1: assert property (@(posedge clk) disable iff (rst)
    sh_start |-> busy);
endmodule

// File: tb/test_auto_xfer_ctrl.sv
module test_auto_xfer_ctrl;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_buf_we = 1'b0;
  logic [AW-1:0] sw_buf_addr = '0;
  logic [DW-1:0] sw_buf_wdata = '0;
  logic [DW-1:0] sw_buf_rdata;
  logic sw_ptr_we = 1'b0;
  logic [AW-1:0] sw_ptr_wdata = '0;
  logic rx_en = 1'b0;
  logic trig_we = 1'b0;
  logic [AW-1:0] ptr;
  logic busy, irq, sck, sdo;
  logic sdi = 1'b0;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] txq [$];
  int slv_idx = 0, slv_bit = 0, slv_salt = 0;
  logic [DW-1:0] slv_cur = '0;
  logic [DW-1:0] mon_sh = '0;
  int mon_bits = 0, sent = 0, irq_cnt = 0, sck_rises = 0;

  always #10 clk = ~clk;

  auto_xfer_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SCK_HALF(2)) i_auto_xfer_ctrl (
    .clk(clk), .rst(rst), .sw_buf_we(sw_buf_we), .sw_buf_addr(sw_buf_addr),
    .sw_buf_wdata(sw_buf_wdata), .sw_buf_rdata(sw_buf_rdata),
    .sw_ptr_we(sw_ptr_we), .sw_ptr_wdata(sw_ptr_wdata), .rx_en(rx_en),
    .trig_we(trig_we), .ptr(ptr), .busy(busy), .irq(irq),
    .sck(sck), .sdo(sdo), .sdi(sdi)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] slv_byte(input int s, input int k);
    return DW'((s * 53) ^ (k * 29) ^ 8'hA5);
  endfunction

  // remote device: new bit after each falling edge
  always @(negedge sck) begin
    if (!rst) begin
      if (slv_bit == 0) slv_cur = slv_byte(slv_salt, slv_idx);
      sdi = slv_cur[DW-1-slv_bit];
    end
  end

  // monitor: capture sdo at rising edges, pop the scoreboard per byte
  always @(posedge sck) begin
    if (!rst) begin
      sck_rises++;
      slv_bit++;
      if (slv_bit == DW) begin
        slv_bit = 0;
        slv_idx++;
      end
      mon_sh = {mon_sh[DW-2:0], sdo};
      mon_bits++;
      if (mon_bits == DW) begin
        mon_bits = 0;
        sent++;
        if (txq.size() == 0) begin
          chk(1'b0, "R2", "unexpected byte", int'(mon_sh), 0);
        end else begin
          logic [DW-1:0] e;
          e = txq.pop_front();
          chk(mon_sh == e, (sent == 1) ? "R1" : "R2", "serial byte", int'(mon_sh), int'(e));
        end
      end
    end
  end

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic sw_write(input int a, input logic [DW-1:0] v);
    @(negedge clk);
    sw_buf_we = 1'b1; sw_buf_addr = AW'(a); sw_buf_wdata = v;
    @(negedge clk);
    sw_buf_we = 1'b0;
  endtask

  task automatic sw_read(input int a, output logic [DW-1:0] v);
    @(negedge clk);
    sw_buf_addr = AW'(a);
    @(negedge clk);
    v = sw_buf_rdata;
  endtask

  // driver: prepares the buffer, pushes expected serial bytes, runs one exchange
  task automatic run_xfer(input int n, input bit rx, input int salt, input bit poke);
    int cyc;
    logic [DW-1:0] rd;
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] v;
      v = DW'(salt * 37 + i * 11 + 5);
      sw_write(i, v);
      model[i] = v;
    end
    for (int k = 0; k < n; k++) txq.push_back(model[n-1-k]);
    slv_idx = 0; slv_bit = 0; slv_salt = salt; mon_bits = 0;
    sent = 0; irq_cnt = 0; sck_rises = 0;
    @(negedge clk);
    sw_ptr_we = 1'b1; sw_ptr_wdata = AW'(n - 1); rx_en = rx;
    @(negedge clk);
    sw_ptr_we = 1'b0; trig_we = 1'b1;
    @(negedge clk);
    trig_we = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", int'(busy), 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      trig_we = 1'b1; sw_buf_we = 1'b1; sw_buf_addr = '0;
      sw_buf_wdata = ~model[0]; sw_ptr_we = 1'b1; sw_ptr_wdata = '0;
      @(negedge clk);
      trig_we = 1'b0; sw_buf_we = 1'b0; sw_ptr_we = 1'b0;
      chk(busy == 1'b1, "R7", "busy during run", int'(busy), 1);
    end
    cyc = 0;
    while (irq_cnt == 0 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    repeat (6) @(negedge clk);
    chk(irq_cnt == 1, "R6", "irq pulses", irq_cnt, 1);
    chk(sent == n, rx ? "R2" : "R4", "bytes sent", sent, n);
    chk(sck_rises == DW * n, "R5", "sck rising edges", sck_rises, DW * n);
    chk(busy == 1'b0, "R7", "busy after done", int'(busy), 0);
    chk(ptr == '0, "R8", "pointer at end", int'(ptr), 0);
    chk(txq.size() == 0, "R2", "bytes left in queue", txq.size(), 0);
    txq.delete();
    if (rx) for (int k = 0; k < n; k++) model[n-1-k] = slv_byte(salt, k);
    for (int a = 0; a < DEPTH; a++) begin
      sw_read(a, rd);
      chk(rd == model[a], rx ? "R3" : "R4", $sformatf("buffer[%0d]", a), int'(rd), int'(model[a]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R9", "reset busy", int'(busy), 0);
    chk(irq == 1'b0, "R9", "reset irq", int'(irq), 0);
    chk(sck == 1'b1, "R9", "reset sck", int'(sck), 1);
    chk(ptr == '0, "R9", "reset ptr", int'(ptr), 0);
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = DW'(8'hC0 + a);
      sw_write(a, model[a]);
    end
    run_xfer(6, 1'b1, 1, 1'b0);   // R1 R2 R3: six-byte exchange
    run_xfer(16, 1'b1, 2, 1'b0);  // R2 R3: full buffer
    run_xfer(4, 1'b0, 3, 1'b1);   // R4 R7: no receive, strobes while busy
    run_xfer(1, 1'b1, 4, 1'b0);   // R10: single byte at offset 0
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule